// File: doc/BRIEF.md
# Store-Miss Ownership Request Selector

This block sits between a core's store path and a coherent fabric and holds one pending store miss for a single cache line. Stores that target the pending line are gathered into a line buffer with a per-byte valid mask. When the miss is sent, the block picks the cheaper of two request kinds. An ownership-only request moves no data and is used when the old contents are not needed: the gathered bytes cover the whole line, or the line is already held in shared state. Otherwise the block sends a read-for-ownership, which returns the line.

Returned data is merged with the gathered store bytes, and the store bytes always win. The block then presents a completion that carries the line address, the data, the byte mask and the final modified state. A store to a line already held exclusive or modified needs no fabric traffic, so it completes at once. Three event counters track ownership-only requests, read-for-ownership requests and shared-to-modified upgrades.

After a first partial store, the block waits a fixed number of cycles for more stores to the same line before it sends the request. A full-line mask or an explicit flush sends the request at once.

Top module: `store_miss_own_sel`

## Requirements
- R1: After reset, st_ready is 1, req_valid and cpl_valid are 0, and all three counters read 0.
- R2: A store accepted while idle, in line state I (code 0) and with all 64 mask bits set, raises req_valid in the next cycle with req_opcode 0x248 (ownership-only). There is no hold wait. Response data for an ownership-only request is ignored.
- R3: A partial store accepted while idle, in state I, with no later store, raises req_valid exactly HOLD_CYCLES cycles after the accepting edge with req_opcode 0x200 (read-for-ownership).
- R4: If stores merged during the hold window together set every mask bit, the request is sent at the edge where coverage completes, with opcode 0x248.
- R5: A store whose mask lacks even one byte does not count as full coverage. A line in state I gathered that way is requested with opcode 0x200.
- R6: A store allocated in line state S (code 1) is requested with opcode 0x248 after the hold window, and the upgrade counter increments.
- R7: A store accepted in line state E (code 2) or M (code 3) issues no request. cpl_valid rises in the next cycle, with cpl_mask equal to the store mask.
- R8: For a read-for-ownership, each completion byte comes from the stores where its mask bit is set and from the response otherwise. cpl_mask is then all ones, and cpl_state is always 3 (M).
- R9: While the miss is pending or outstanding, stores to the same line are accepted and merged. A store to any other line sees st_ready = 0.
- R10: st_flush on a store dispatches the request in the next cycle without waiting for the hold window.
- R11: Each request handshake increments exactly one of the ownership-only and read-for-ownership counters, and increments the upgrade counter as well when the line was in S.
- R12: In the cycle after the completion handshake, cpl_valid and st_ready are both 0. In the following cycle, st_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store accepted this cycle |
| st_line_addr | input | ADDR_W | Line address of the store |
| st_data | input | LINE_BYTES*8 | Store data aligned to the line |
| st_mask | input | LINE_BYTES | Byte enables of the store |
| st_line_state | input | 2 | Cache state of the line: 0 I, 1 S, 2 E, 3 M |
| st_flush | input | 1 | Dispatch the pending miss at once |
| req_valid | output | 1 | Fabric request valid |
| req_ready | input | 1 | Fabric accepts the request |
| req_opcode | output | OPC_W | 0x248 ownership-only, 0x200 read-for-ownership |
| req_line_addr | output | ADDR_W | Requested line address |
| rsp_valid | input | 1 | Fabric response (single cycle) |
| rsp_data | input | LINE_BYTES*8 | Line data returned for a read-for-ownership |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion accepted |
| cpl_line_addr | output | ADDR_W | Completed line address |
| cpl_data | output | LINE_BYTES*8 | Merged line data |
| cpl_mask | output | LINE_BYTES | Valid bytes of cpl_data |
| cpl_state | output | 2 | Final line state, always 3 (M) |
| cnt_own | output | CNT_W | Ownership-only requests sent |
| cnt_rfo | output | CNT_W | Read-for-ownership requests sent |
| cnt_upgrade | output | CNT_W | Shared-to-modified upgrades sent |

## Verification
Each result has a fixed due cycle. A full-line or flushed store raises req_valid one cycle after its accepting edge. A partial store raises it exactly HOLD_CYCLES cycles later, and a store that completes coverage inside the window raises it one cycle after that store. An exclusive or modified hit raises cpl_valid one cycle after acceptance, and a fabric response raises it one cycle after the response. The counters change on the request handshake edge, and st_ready stays low for exactly one cycle after the completion handshake. The bench drives and samples only at falling edges. For a timed result it counts those edges from the stimulus and checks the output is still low before its due edge and high at it, so an early or late result is reported.

// File: rtl/sos_pkg.sv
package sos_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_state_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_REQ  = 3'd2,
    ST_WAIT = 3'd3,
    ST_CPL  = 3'd4,
    ST_DONE = 3'd5
  } fsm_e;
endpackage

// File: rtl/sos_line_buffer.sv
module sos_line_buffer #(
  parameter int LINE_BYTES = 64,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  st_we,
  input  logic [LINE_W-1:0]     st_data,
  input  logic [LINE_BYTES-1:0] st_mask,
  input  logic                  rsp_we,
  input  logic [LINE_W-1:0]     rsp_data,
  output logic [LINE_W-1:0]     data_q,
  output logic [LINE_BYTES-1:0] mask_q,
  output logic [LINE_BYTES-1:0] mask_d
);

  logic [LINE_BYTES-1:0] base_mask;
  logic [LINE_W-1:0]     data_d;
  logic                  data_en;
  logic                  mask_en;

  assign base_mask = clr ? '0 : mask_q;
  assign data_en   = st_we | rsp_we;
  assign mask_en   = clr | st_we | rsp_we;

  always_comb begin
    mask_d = base_mask;
    if (st_we)  mask_d = mask_d | st_mask;
    if (rsp_we) mask_d = '1;
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    always_comb begin
      if (st_we && st_mask[b])
        data_d[b*8 +: 8] = st_data[b*8 +: 8];
      else if (rsp_we && !base_mask[b])
        data_d[b*8 +: 8] = rsp_data[b*8 +: 8];
      else
        data_d[b*8 +: 8] = data_q[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
  end

  // R8: a store byte beats a same-cycle response byte
  p_store_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_mask[0]) |=> (data_q[7:0] == $past(st_data[7:0])));

endmodule

// File: rtl/sos_req_select.sv
module sos_req_select
  import sos_pkg::*;
(
  input  logic [1:0] line_state,
  input  logic       full_cover,
  output logic       use_own,
  output logic       is_upgrade
);

  always_comb begin
    is_upgrade = (line_state == LS_S);
    use_own    = full_cover | is_upgrade;
  end

endmodule

// File: rtl/sos_event_counters.sv
module sos_event_counters #(
  parameter int NUM   = 3,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt_q
);

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_d;
    assign cnt_d = cnt_q[i] + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[i] <= '0;
      else if (inc[i]) cnt_q[i] <= cnt_d;
    end

    // R11: a counter moves by exactly one
    p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] != $past(cnt_q[i])) |-> (cnt_q[i] == $past(cnt_q[i]) + 1'b1));
  end

endmodule

// File: rtl/store_miss_own_sel.sv
module store_miss_own_sel
  import sos_pkg::*;
#(
  parameter int          LINE_BYTES  = 64,
  parameter int          ADDR_W      = 26,
  parameter int          HOLD_CYCLES = 4,
  parameter int          CNT_W       = 16,
  parameter int          OPC_W       = 12,
  parameter logic [11:0] OPC_OWN     = 12'h248,
  parameter logic [11:0] OPC_RFO     = 12'h200,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [ADDR_W-1:0]     st_line_addr,
  input  logic [LINE_W-1:0]     st_data,
  input  logic [LINE_BYTES-1:0] st_mask,
  input  logic [1:0]            st_line_state,
  input  logic                  st_flush,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [OPC_W-1:0]      req_opcode,
  output logic [ADDR_W-1:0]     req_line_addr,
  input  logic                  rsp_valid,
  input  logic [LINE_W-1:0]     rsp_data,
  output logic                  cpl_valid,
  input  logic                  cpl_ready,
  output logic [ADDR_W-1:0]     cpl_line_addr,
  output logic [LINE_W-1:0]     cpl_data,
  output logic [LINE_BYTES-1:0] cpl_mask,
  output logic [1:0]            cpl_state,
  output logic [CNT_W-1:0]      cnt_own,
  output logic [CNT_W-1:0]      cnt_rfo,
  output logic [CNT_W-1:0]      cnt_upgrade
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  fsm_e              state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        lstate_q;
  logic              ctx_en;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              own_q, own_d, upg_q, upg_d, flag_en;

  logic idle, same_line, merging, st_fire, alloc, hit_em, hold_last;
  logic req_fire, rsp_take;
  logic [LINE_W-1:0]     buf_data;
  logic [LINE_BYTES-1:0] buf_mask, mask_next;
  logic                  full_next;
  logic [1:0]            sel_state;
  logic                  sel_own, sel_upg;

  assign idle      = (state_q == ST_IDLE);
  assign merging   = (state_q == ST_HOLD) || (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign same_line = (st_line_addr == addr_q);
  assign st_ready  = idle || (merging && same_line);
  assign st_fire   = st_valid && st_ready;
  assign alloc     = idle && st_fire;
  assign hit_em    = st_line_state[1];
  assign hold_last = (hold_q == HOLD_W'(HOLD_CYCLES - 1));
  assign req_fire  = req_valid && req_ready;
  assign rsp_take  = (state_q == ST_WAIT) && rsp_valid && !own_q;
  assign full_next = &mask_next;
  assign sel_state = idle ? st_line_state : lstate_q;

  sos_line_buffer #(.LINE_BYTES(LINE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (alloc),
    .st_we    (st_fire),
    .st_data  (st_data),
    .st_mask  (st_mask),
    .rsp_we   (rsp_take),
    .rsp_data (rsp_data),
    .data_q   (buf_data),
    .mask_q   (buf_mask),
    .mask_d   (mask_next)
  );

  sos_req_select u_sel (
    .line_state (sel_state),
    .full_cover (full_next),
    .use_own    (sel_own),
    .is_upgrade (sel_upg)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    hold_en = 1'b0;
    ctx_en  = 1'b0;
    own_d   = own_q;
    upg_d   = upg_q;
    flag_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (alloc) begin
          ctx_en  = 1'b1;
          hold_en = 1'b1;
          hold_d  = '0;
          flag_en = 1'b1;
          if (hit_em) begin
            own_d   = 1'b1;
            upg_d   = 1'b0;
            state_d = ST_CPL;
          end else begin
            own_d   = sel_own;
            upg_d   = sel_upg;
            state_d = (full_next || st_flush) ? ST_REQ : ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (full_next || (st_fire && st_flush) || hold_last) begin
          flag_en = 1'b1;
          own_d   = sel_own;
          upg_d   = sel_upg;
          state_d = ST_REQ;
        end else begin
          hold_en = 1'b1;
          hold_d  = hold_q + 1'b1;
        end
      end
      ST_REQ:  if (req_fire)  state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid) state_d = ST_CPL;
      ST_CPL:  if (cpl_ready) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q   <= '0;
      lstate_q <= LS_I;
    end else if (ctx_en) begin
      addr_q   <= st_line_addr;
      lstate_q <= st_line_state;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      own_q <= 1'b0;
      upg_q <= 1'b0;
    end else if (flag_en) begin
      own_q <= own_d;
      upg_q <= upg_d;
    end
  end

  // outputs
  assign req_valid     = (state_q == ST_REQ);
  assign req_opcode    = own_q ? OPC_W'(OPC_OWN) : OPC_W'(OPC_RFO);
  assign req_line_addr = addr_q;
  assign cpl_valid     = (state_q == ST_CPL);
  assign cpl_line_addr = addr_q;
  assign cpl_data      = buf_data;
  assign cpl_mask      = buf_mask;
  assign cpl_state     = LS_M;

  logic [2:0]            cnt_inc;
  logic [2:0][CNT_W-1:0] cnt_vec;

  assign cnt_inc = {req_fire && upg_q, req_fire && !own_q, req_fire && own_q};

  sos_event_counters #(.NUM(3), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (cnt_inc),
    .cnt_q (cnt_vec)
  );

  assign cnt_own     = cnt_vec[0];
  assign cnt_rfo     = cnt_vec[1];
  assign cnt_upgrade = cnt_vec[2];

  // R2: a pending request holds its type and address until accepted
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_opcode) && $stable(req_line_addr)));

  // R4: a fully covered line never goes out as a read-for-ownership
  p_full_own_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(req_valid) && (&buf_mask)) |-> (req_opcode == OPC_W'(OPC_OWN)));

  // R7: an exclusive or modified hit skips the fabric
  p_em_no_req_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alloc && hit_em) |=> (cpl_valid && !req_valid));

  // R8: after a read-for-ownership every completion byte is valid
  p_rfo_full_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpl_valid && !own_q) |-> (&cpl_mask));

  // R9: another line is held off while a miss is outstanding
  p_other_line_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_WAIT) && st_valid && (st_line_addr != addr_q)) |-> !st_ready);

  // R12: one quiet cycle after the completion handshake
  p_done_gap_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpl_valid && cpl_ready) |=> (!cpl_valid && !st_ready));

endmodule

// File: tb/store_miss_own_sel_tb.sv
module store_miss_own_sel_tb;
  localparam int LB   = 64;
  localparam int LW   = LB * 8;
  localparam int AW   = 26;
  localparam int HOLD = 4;
  localparam int CW   = 16;
  localparam logic [11:0] OWN = 12'h248;
  localparam logic [11:0] RFO = 12'h200;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid, st_ready, st_flush;
  logic [AW-1:0] st_line_addr;
  logic [LW-1:0] st_data;
  logic [LB-1:0] st_mask;
  logic [1:0]    st_line_state;
  logic          req_valid, req_ready;
  logic [11:0]   req_opcode;
  logic [AW-1:0] req_line_addr;
  logic          rsp_valid;
  logic [LW-1:0] rsp_data;
  logic          cpl_valid, cpl_ready;
  logic [AW-1:0] cpl_line_addr;
  logic [LW-1:0] cpl_data;
  logic [LB-1:0] cpl_mask;
  logic [1:0]    cpl_state;
  logic [CW-1:0] cnt_own, cnt_rfo, cnt_upgrade;

  int checks = 0;
  int errors = 0;
  int exp_own = 0, exp_rfo = 0, exp_upg = 0;

  store_miss_own_sel #(.LINE_BYTES(LB), .ADDR_W(AW), .HOLD_CYCLES(HOLD), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_line_addr(st_line_addr),
    .st_data(st_data), .st_mask(st_mask), .st_line_state(st_line_state), .st_flush(st_flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
    .req_line_addr(req_line_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_line_addr(cpl_line_addr),
    .cpl_data(cpl_data), .cpl_mask(cpl_mask), .cpl_state(cpl_state),
    .cnt_own(cnt_own), .cnt_rfo(cnt_rfo), .cnt_upgrade(cnt_upgrade)
  );

  always #5 clk = ~clk;

  function automatic logic [LW-1:0] pat(input logic [7:0] seed);
    logic [LW-1:0] v;
    for (int i = 0; i < LB; i++) v[i*8 +: 8] = seed + 8'(i);
    return v;
  endfunction

  function automatic logic [LW-1:0] bitmask(input logic [LB-1:0] m);
    logic [LW-1:0] v;
    for (int i = 0; i < LB; i++) v[i*8 +: 8] = {8{m[i]}};
    return v;
  endfunction

  function automatic logic [LW-1:0] merge(input logic [LW-1:0] a, input logic [LW-1:0] b,
                                          input logic [LB-1:0] m);
    return (a & bitmask(m)) | (b & ~bitmask(m));
  endfunction

  task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk_counts(input string tag);
    chk({tag, " cnt_own"},     LW'(cnt_own),     LW'(exp_own));
    chk({tag, " cnt_rfo"},     LW'(cnt_rfo),     LW'(exp_rfo));
    chk({tag, " cnt_upgrade"}, LW'(cnt_upgrade), LW'(exp_upg));
  endtask

  // drive one store for one clock edge; starts and ends just after a falling edge
  task automatic put_store(input logic [AW-1:0] a, input logic [LW-1:0] d,
                           input logic [LB-1:0] m, input logic [1:0] ls, input logic fl);
    st_valid = 1'b1; st_line_addr = a; st_data = d; st_mask = m;
    st_line_state = ls; st_flush = fl;
    #1 chk("R9 st_ready before store", LW'(st_ready), LW'(1'b1));
    @(negedge clk);
    st_valid = 1'b0; st_flush = 1'b0;
  endtask

  task automatic take_req(input logic [11:0] opc, input logic [AW-1:0] a, input string tag);
    chk({tag, " req_valid"}, LW'(req_valid), LW'(1'b1));
    chk({tag, " req_opcode"}, LW'(req_opcode), LW'(opc));
    chk({tag, " req_line_addr"}, LW'(req_line_addr), LW'(a));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk({tag, " req dropped after handshake"}, LW'(req_valid), LW'(1'b0));
  endtask

  task automatic send_rsp(input logic [LW-1:0] d);
    rsp_valid = 1'b1; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic take_cpl(input logic [LW-1:0] d, input logic [LB-1:0] m,
                          input logic [AW-1:0] a, input string tag);
    chk({tag, " cpl_valid"}, LW'(cpl_valid), LW'(1'b1));
    chk({tag, " cpl_mask"}, LW'(cpl_mask), LW'(m));
    chk({tag, " cpl_data"}, cpl_data & bitmask(m), d & bitmask(m));
    chk({tag, " cpl_line_addr"}, LW'(cpl_line_addr), LW'(a));
    chk("R8 cpl_state is M", LW'(cpl_state), LW'(2'd3));
    cpl_ready = 1'b1;
    @(negedge clk);
    cpl_ready = 1'b0;
    chk("R12 cpl_valid low after handshake", LW'(cpl_valid), LW'(1'b0));
    chk("R12 st_ready low one cycle", LW'(st_ready), LW'(1'b0));
    @(negedge clk);
    chk("R12 st_ready back", LW'(st_ready), LW'(1'b1));
  endtask

  task automatic t_reset;
    chk("R1 st_ready", LW'(st_ready), LW'(1'b1));
    chk("R1 req_valid", LW'(req_valid), LW'(1'b0));
    chk("R1 cpl_valid", LW'(cpl_valid), LW'(1'b0));
    chk_counts("R1");
  endtask

  task automatic t_full_line;
    put_store(26'h11, pat(8'h10), '1, 2'd0, 1'b0);
    take_req(OWN, 26'h11, "R2 full line");
    exp_own++;
    chk_counts("R11 after R2");
    send_rsp(pat(8'hEE));
    take_cpl(pat(8'h10), '1, 26'h11, "R2 ownership data ignored");
  endtask

  task automatic t_partial_rfo;
    logic [LW-1:0] e;
    put_store(26'h22, pat(8'h20), 64'hFF, 2'd0, 1'b0);
    chk("R3 req not before hold", LW'(req_valid), LW'(1'b0));
    for (int i = 1; i <= HOLD; i++) begin
      @(negedge clk);
      chk("R3 hold timing", LW'(req_valid), LW'(i == HOLD));
    end
    take_req(RFO, 26'h22, "R3 partial line");
    exp_rfo++;
    chk_counts("R11 after R3");
    // other line blocked while outstanding
    st_valid = 1'b1; st_line_addr = 26'h23; st_mask = '1; st_line_state = 2'd0;
    #1 chk("R9 other line blocked", LW'(st_ready), LW'(1'b0));
    st_valid = 1'b0;
    put_store(26'h22, pat(8'h40), 64'h400, 2'd0, 1'b0);
    send_rsp(pat(8'h80));
    e = merge(pat(8'h40), merge(pat(8'h20), pat(8'h80), 64'hFF), 64'h400);
    take_cpl(e, '1, 26'h22, "R8 R9 merged rfo line");
  endtask

  task automatic t_merge_full;
    logic [LB-1:0] lo = 64'h0000_0000_FFFF_FFFF;
    put_store(26'h33, pat(8'h30), lo, 2'd0, 1'b0);
    chk("R4 no req after first half", LW'(req_valid), LW'(1'b0));
    put_store(26'h33, pat(8'h50), ~lo, 2'd0, 1'b0);
    take_req(OWN, 26'h33, "R4 merged coverage");
    exp_own++;
    send_rsp(pat(8'hAA));
    take_cpl(merge(pat(8'h30), pat(8'h50), lo), '1, 26'h33, "R4 merged data");
  endtask

  task automatic t_masked_wide;
    logic [LB-1:0] m = {1'b0, {63{1'b1}}};
    put_store(26'h44, pat(8'h60), m, 2'd0, 1'b0);
    for (int i = 1; i <= HOLD; i++) @(negedge clk);
    take_req(RFO, 26'h44, "R5 one byte missing");
    exp_rfo++;
    send_rsp(pat(8'h90));
    take_cpl(merge(pat(8'h60), pat(8'h90), m), '1, 26'h44, "R5 fill byte 63");
  endtask

  task automatic t_upgrade;
    put_store(26'h55, pat(8'h70), 64'hF, 2'd1, 1'b0);
    for (int i = 1; i <= HOLD; i++) @(negedge clk);
    take_req(OWN, 26'h55, "R6 shared upgrade");
    exp_own++; exp_upg++;
    chk_counts("R11 R6 after upgrade");
    send_rsp(pat(8'h00));
    take_cpl(pat(8'h70), 64'hF, 26'h55, "R6 upgrade mask");
  endtask

  task automatic t_hit_em;
    put_store(26'h66, pat(8'hB0), 64'hF0, 2'd2, 1'b0);
    chk("R7 no req on E hit", LW'(req_valid), LW'(1'b0));
    take_cpl(pat(8'hB0), 64'hF0, 26'h66, "R7 E hit");
    put_store(26'h67, pat(8'hC0), 64'h3, 2'd3, 1'b0);
    chk("R7 no req on M hit", LW'(req_valid), LW'(1'b0));
    take_cpl(pat(8'hC0), 64'h3, 26'h67, "R7 M hit");
    chk_counts("R7 R11 counters unchanged");
  endtask

  task automatic t_flush;
    put_store(26'h77, pat(8'hD0), 64'hF00, 2'd0, 1'b1);
    take_req(RFO, 26'h77, "R10 flush dispatch");
    exp_rfo++;
    send_rsp(pat(8'h05));
    take_cpl(merge(pat(8'hD0), pat(8'h05), 64'hF00), '1, 26'h77, "R10 flush data");
    chk_counts("R11 final");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report;
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    st_valid = 1'b0; st_flush = 1'b0; st_line_addr = '0; st_data = '0;
    st_mask = '0; st_line_state = 2'd0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; cpl_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_full_line;
    t_partial_rfo;
    t_merge_full;
    t_masked_wide;
    t_upgrade;
    t_hit_em;
    t_flush;
    report;
    $finish;
  end

endmodule